// File: doc/BRIEF.md
# Masked Address Decoder with Miss Select

This block takes one request from an address channel and turns its address into a one-hot target select. There are `NUM_TGT` real targets, plus one extra select bit. That extra bit is raised when no target claims the address. Each target k owns the addresses for which `addr & mask_k == base_k`. The bases and masks arrive as two packed parameter arrays, with target 0 in the least significant slice.

An opaque sideband payload travels with the address. The decode, the address and the payload leave together on a valid/stall handshake. When `REGISTERED` is set, a one-entry output register sits between the two handshakes. When it is clear, the path is purely combinational. The parameter set is checked at time zero, and an illegal map is flagged in simulation.

A request is taken on a clock edge when `in_valid` is high and `in_stall` is low. A result is taken downstream when `out_valid` is high and `out_stall` is low.

Top module: `addr_route_decode`

## Requirements
- R1: When `in_addr & TGT_MASK[k] == TGT_BASE[k]`, select bit k (bit position k of `out_sel`) is set for the decoded request.
- R2: When no target matches, only bit `NUM_TGT` (the miss bit) of `out_sel` is set. Any valid output carries exactly one set select bit.
- R3: A base with a bit set outside its own mask is an illegal configuration and is flagged at time zero. The package check `base_fits` returns 0 for such a pair.
- R4: Two targets whose regions share an address are an illegal configuration and are flagged at time zero. The package check `regions_overlap` returns 1 for such a pair.
- R5: With `REGISTERED`=1, an accepted request appears on the outputs one clock after the edge that accepts it.
- R6: With `REGISTERED`=1, the output register loads whenever it is empty or being drained. `in_stall` is high only while `out_valid` and `out_stall` are both high.
- R7: With `REGISTERED`=1, a result that is stalled downstream holds valid and keeps every output bit unchanged. The waiting upstream request is not lost and is delivered once the stall clears.
- R8: With `REGISTERED`=0, the outputs follow the inputs in the same cycle, and `in_stall` equals `out_stall`.
- R9: A synchronous active-high `rst` clears `out_valid` on the next edge.
- R10: `out_addr` and `out_pay` carry the request's address and payload unchanged alongside its decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_stall | output | 1 | Request cannot be taken this cycle |
| in_addr | input | ADDR_W | Request address |
| in_pay | input | PAY_W | Opaque sideband carried with the address |
| out_valid | output | 1 | Decoded result present |
| out_stall | input | 1 | Downstream cannot take the result |
| out_sel | output | NUM_TGT+1 | One-hot select; the top bit is the miss bit |
| out_addr | output | ADDR_W | Address of the result |
| out_pay | output | PAY_W | Payload of the result |

## Verification
The one-hot assertion assumes the parameter map has passed its time-zero checks, so no address can match two regions. The bench uses a legal four-target map with two holes, and it probes the illegal cases only through the package functions.

The hold and acceptance assertions assume that upstream presents a request as a plain valid level. The bench changes the address while the request is stalled, to show that only the accepted value is captured. It sweeps every address of the 8-bit space through both the registered and the combinational variants. Expected selects are computed from the region boundaries written as numeric ranges.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;

  localparam int WORD_W = 64;
  typedef logic [WORD_W-1:0] word_t;

  // A region claims an address when the masked bits equal the base.
  function automatic logic region_hit(input word_t addr, input word_t base,
                                      input word_t mask);
    return (addr & mask) == base;
  endfunction

  // A base is legal only if every set bit lies inside its mask.
  function automatic logic base_fits(input word_t base, input word_t mask);
    return (base & ~mask) == '0;
  endfunction

  // Two regions share an address when they agree on every bit both care about.
  function automatic logic regions_overlap(input word_t base_a, input word_t mask_a,
                                           input word_t base_b, input word_t mask_b);
    return ((base_a ^ base_b) & mask_a & mask_b) == '0;
  endfunction

endpackage

// File: rtl/addr_route_match.sv
module addr_route_match
  import addr_route_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_TGT = 4,
  parameter logic [NUM_TGT*ADDR_W-1:0] TGT_BASE = '0,
  parameter logic [NUM_TGT*ADDR_W-1:0] TGT_MASK = '0,
  localparam int SEL_W = NUM_TGT + 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SEL_W-1:0]  sel
);

  logic [NUM_TGT-1:0] hit_vec;
  logic               miss;

  for (genvar k = 0; k < NUM_TGT; k++) begin : g_region
    localparam logic [ADDR_W-1:0] BASE_K = TGT_BASE[k*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] MASK_K = TGT_MASK[k*ADDR_W +: ADDR_W];
    assign hit_vec[k] = region_hit(WORD_W'(addr), WORD_W'(BASE_K), WORD_W'(MASK_K));
  end

  assign miss = ~|hit_vec;
  assign sel  = {miss, hit_vec};

endmodule

// File: rtl/addr_route_stage.sv
module addr_route_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_stall,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_stall,
  output logic [DATA_W-1:0] out_data
);

  logic              vld_q;
  logic [DATA_W-1:0] data_q;
  logic              take;
  logic              blocked;

  // Register is busy only when it holds a result that downstream refuses.
  assign blocked  = vld_q && out_stall;
  assign take     = in_valid && !blocked;
  assign in_stall = blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (!blocked) begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      data_q <= in_data;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;

  // R5: an accepted request is visible on the next cycle
  a_r5_next_cycle: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_stall) |=> (out_valid && out_data == $past(in_data)));

  // R7: a stalled result is held intact
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_stall) |=> (out_valid && $stable(out_data)));

  // R6: an empty register never pushes back
  a_r6_empty_accepts: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !in_stall);

  // R9: reset empties the stage
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

// File: rtl/addr_route_decode.sv
module addr_route_decode
  import addr_route_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAY_W = 6,
  parameter int NUM_TGT = 4,
  parameter logic [NUM_TGT*ADDR_W-1:0] TGT_BASE = {8'hF0, 8'h80, 8'h40, 8'h00},
  parameter logic [NUM_TGT*ADDR_W-1:0] TGT_MASK = {8'hF0, 8'hC0, 8'hE0, 8'hC0},
  parameter bit REGISTERED = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_stall,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [PAY_W-1:0]   in_pay,
  output logic               out_valid,
  input  logic               out_stall,
  output logic [NUM_TGT:0]   out_sel,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [PAY_W-1:0]   out_pay
);

  localparam int SEL_W = NUM_TGT + 1;
  localparam int BUS_W = SEL_W + ADDR_W + PAY_W;

  logic [SEL_W-1:0] dec_sel;
  logic [BUS_W-1:0] in_bus;
  logic [BUS_W-1:0] out_bus;

  addr_route_match #(
    .ADDR_W  (ADDR_W),
    .NUM_TGT (NUM_TGT),
    .TGT_BASE(TGT_BASE),
    .TGT_MASK(TGT_MASK)
  ) u_match (
    .addr(in_addr),
    .sel (dec_sel)
  );

  assign in_bus = {dec_sel, in_addr, in_pay};

  if (REGISTERED) begin : g_reg
    addr_route_stage #(
      .DATA_W(BUS_W)
    ) u_stage (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_stall (in_stall),
      .in_data  (in_bus),
      .out_valid(out_valid),
      .out_stall(out_stall),
      .out_data (out_bus)
    );
  end else begin : g_comb
    assign out_valid = in_valid;
    assign in_stall  = out_stall;
    assign out_bus   = in_bus;
  end

  assign {out_sel, out_addr, out_pay} = out_bus;

  // Configuration checks made once at time zero (R3, R4)
  initial begin
    for (int i = 0; i < NUM_TGT; i++) begin
      a_r3_base_in_mask: assert (base_fits(WORD_W'(TGT_BASE[i*ADDR_W +: ADDR_W]),
                                           WORD_W'(TGT_MASK[i*ADDR_W +: ADDR_W])))
        else $error("target %0d base has bits outside its mask", i);
      for (int j = i + 1; j < NUM_TGT; j++) begin
        a_r4_no_overlap: assert (!regions_overlap(
            WORD_W'(TGT_BASE[i*ADDR_W +: ADDR_W]), WORD_W'(TGT_MASK[i*ADDR_W +: ADDR_W]),
            WORD_W'(TGT_BASE[j*ADDR_W +: ADDR_W]), WORD_W'(TGT_MASK[j*ADDR_W +: ADDR_W])))
          else $error("targets %0d and %0d claim a common address", i, j);
      end
    end
  end

  // R2: a presented result names exactly one destination
  a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(out_sel) == 1));

  // R1/R2: the miss bit and the real hits exclude each other on the decoder
  a_r2_miss_exclusive: assert property (@(posedge clk) disable iff (rst)
    dec_sel[NUM_TGT] |-> (dec_sel[NUM_TGT-1:0] == '0));

endmodule

// File: tb/addr_route_decode_bench.sv
module addr_route_decode_bench;

  localparam int AW = 8;
  localparam int PW = 6;
  localparam int NT = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [PW-1:0] in_pay = '0;
  logic          out_stall = 1'b0;

  logic          r_in_stall, r_out_valid;
  logic [NT:0]   r_sel;
  logic [AW-1:0] r_addr;
  logic [PW-1:0] r_pay;
  logic          c_in_stall, c_out_valid;
  logic [NT:0]   c_sel;
  logic [AW-1:0] c_addr;
  logic [PW-1:0] c_pay;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  addr_route_decode #(.REGISTERED(1'b1)) u_addr_route_decode (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_stall(r_in_stall),
    .in_addr(in_addr), .in_pay(in_pay), .out_valid(r_out_valid),
    .out_stall(out_stall), .out_sel(r_sel), .out_addr(r_addr), .out_pay(r_pay)
  );

  addr_route_decode #(.REGISTERED(1'b0)) u_addr_route_decode_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_stall(c_in_stall),
    .in_addr(in_addr), .in_pay(in_pay), .out_valid(c_out_valid),
    .out_stall(out_stall), .out_sel(c_sel), .out_addr(c_addr), .out_pay(c_pay)
  );

  // Region boundaries restated as plain numeric ranges; 4 means miss.
  function automatic int exp_idx(input int a);
    if (a < 64)  return 0;
    if (a < 96)  return 1;
    if (a < 128) return 4;
    if (a < 192) return 2;
    if (a < 240) return 4;
    return 3;
  endfunction

  function automatic logic [NT:0] exp_sel(input int a);
    return (NT+1)'(1) << exp_idx(a);
  endfunction

  function automatic logic [PW-1:0] pay_of(input int a);
    return PW'((a * 7 + 3) % 64);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_out(input bit regd, input int a);
    logic [NT:0] s;
    logic [AW-1:0] ad;
    logic [PW-1:0] p;
    logic v;
    string sel_tag;
    s  = regd ? r_sel : c_sel;
    ad = regd ? r_addr : c_addr;
    p  = regd ? r_pay : c_pay;
    v  = regd ? r_out_valid : c_out_valid;
    sel_tag = (exp_idx(a) == 4) ? "R2 miss select" : "R1 target select";
    check(v == 1'b1, regd ? "R5 valid one cycle later" : "R8 valid same cycle", v, 1);
    check(s == exp_sel(a), sel_tag, s, exp_sel(a));
    check(ad == AW'(a), "R10 address passthrough", ad, a);
    check(p == pay_of(a), "R10 payload passthrough", p, pay_of(a));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(r_out_valid == 1'b0, "R9 reset state", r_out_valid, 0);
    rst = 1'b0;

    // Full sweep, no stall
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      if (a > 0) check_out(1'b1, a - 1);
      in_valid = 1'b1;
      in_addr  = AW'(a);
      in_pay   = pay_of(a);
      #1;
      check_out(1'b0, a);
      check(c_in_stall == 1'b0, "R8 comb stall follows", c_in_stall, 0);
    end
    @(negedge clk);
    check_out(1'b1, 255);

    // Drain, then hold under stall
    in_valid = 1'b0;
    @(negedge clk);
    check(r_out_valid == 1'b0, "R6 drained", r_out_valid, 0);
    out_stall = 1'b1;
    in_valid  = 1'b1;
    in_addr   = 8'h45;
    in_pay    = pay_of(8'h45);
    #1;
    check(r_in_stall == 1'b0, "R6 empty register accepts under stall", r_in_stall, 0);
    check(c_in_stall == 1'b1, "R8 comb stall equals downstream", c_in_stall, 1);
    @(negedge clk);
    check_out(1'b1, 8'h45);
    check(r_in_stall == 1'b1, "R6 stall when full and stalled", r_in_stall, 1);
    in_addr = 8'hC8;
    in_pay  = pay_of(8'hC8);
    repeat (3) @(negedge clk);
    check(r_addr == 8'h45, "R7 held address", r_addr, 8'h45);
    check(r_sel == exp_sel(8'h45), "R7 held select", r_sel, exp_sel(8'h45));
    check(r_out_valid == 1'b1, "R7 held valid", r_out_valid, 1);
    out_stall = 1'b0;
    #1;
    check(r_in_stall == 1'b0, "R6 stall released with drain", r_in_stall, 0);
    @(negedge clk);
    check_out(1'b1, 8'hC8);
    in_valid = 1'b0;
    @(negedge clk);
    check(r_out_valid == 1'b0, "R6 empties after drain", r_out_valid, 0);

    // Reset while busy
    in_valid = 1'b1;
    in_addr  = 8'hF3;
    in_pay   = pay_of(8'hF3);
    @(negedge clk);
    check_out(1'b1, 8'hF3);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check(r_out_valid == 1'b0, "R9 reset clears valid", r_out_valid, 0);
    rst = 1'b0;

    // Configuration checks through the package functions
    check(addr_route_pkg::base_fits(64'h21, 64'hF0) == 1'b0, "R3 base outside mask",
          addr_route_pkg::base_fits(64'h21, 64'hF0), 0);
    check(addr_route_pkg::base_fits(64'h20, 64'hF0) == 1'b1, "R3 legal base",
          addr_route_pkg::base_fits(64'h20, 64'hF0), 1);
    check(addr_route_pkg::regions_overlap(64'h40, 64'hC0, 64'h60, 64'hE0) == 1'b1,
          "R4 nested regions overlap",
          addr_route_pkg::regions_overlap(64'h40, 64'hC0, 64'h60, 64'hE0), 1);
    check(addr_route_pkg::regions_overlap(64'h40, 64'hE0, 64'h80, 64'hC0) == 1'b0,
          "R4 disjoint regions",
          addr_route_pkg::regions_overlap(64'h40, 64'hE0, 64'h80, 64'hC0), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule